// File: doc/BRIEF.md
# Addressable Variable-Tap Delay Line

This block delays a parallel data word by a number of clock cycles. In fixed mode the delay is a parameter. In variable mode the delay is picked each cycle by an address input, which reads one tap of a shift chain. Every stage of the chain shifts on every enabled clock, so a new address takes effect at once and needs no refill. The block suits delay matching in datapaths and short FIFO-like buffers where the read position moves at run time.

An optional clock enable stalls the whole line. An optional output register can be cleared, set to all ones or loaded with a parameter value from synchronous control inputs. Parameters choose whether clear or set wins when both are asserted, and whether the controls override the clock enable or wait for it. A speed option puts registers behind the tap multiplexer. The register contents after reset come from parameters: one value for the output register and one fill pattern for every stage of the chain.

Top module: `vtap_delay`

## Requirements
- R1: A reset clock edge loads PWRON_VAL into the output register and FILL_VAL into every chain stage and pipeline register. These fill words then reach the output before any data word.
- R2: In fixed mode, a word sampled at `d` on an enabled edge appears at `q` after exactly DEPTH enabled edges. The output register, when present, counts as one of those DEPTH stages.
- R3: In variable mode, address value k gives a delay of k+1 chain stages, plus the speed pipeline stages, plus one stage if the output register is present. An address at or above DEPTH selects the deepest stage.
- R4: Changing `addr` needs no flush. The output that follows the change carries the word already stored at the new tap.
- R5: While the effective clock enable is low and no control is acting, every chain stage, pipeline register and the output register holds its value.
- R6: With SPEED set in variable mode, the tap read is registered, which adds one cycle. When DEPTH is above 256 a second multiplexer stage adds one more cycle. These registers follow the clock enable only.
- R7: `sclr` loads all zeros and `sset` loads all ones into the output register on the next edge. When both are high, CLEAR_WINS=1 gives zeros and CLEAR_WINS=0 gives ones.
- R8: With CTRL_OVER_CE=1 the controls act whatever the value of `ce`. With CTRL_OVER_CE=0 they act only on edges where `ce` is high. Without a clock enable the parameter has no effect.
- R9: `sinit` loads INIT_VAL into the output register on the next valid edge. When HAS_SINIT is set, `sclr` and `sset` have no effect. No control has any effect unless the output register is present.
- R10: The controls never touch the chain or the pipeline registers. On the edge after a control pulse, the output again carries the stream word it would have carried without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the parameter start values |
| ce | input | 1 | Clock enable; ignored when HAS_CE=0 |
| d | input | WIDTH | Data word entering the line |
| addr | input | AW | Tap select in variable mode (AW = ceil(log2(DEPTH)), at least 1) |
| sclr | input | 1 | Synchronous clear of the output register |
| sset | input | 1 | Synchronous set of the output register |
| sinit | input | 1 | Synchronous load of INIT_VAL into the output register |
| q | output | WIDTH | Delayed data word |

## Verification
The bench builds two instances. The first is variable mode, depth 16, with the output register, speed pipeline, clock enable and clear/set, clear winning and the controls gated by the enable. It reaches the tap latency for every address, lossless address moves, stalls, and the clear-over-set tie. The second is fixed mode, depth 5, with init enabled, set also configured, and the controls overriding the enable. It reaches the exact fixed delay including the output stage, init acting while stalled, and set being ignored next to init. The two instances use different fill and power-on words, so the output shows the reset contents of each one as they flush out.

// File: rtl/vtap_pkg.sv
package vtap_pkg;

    typedef enum logic {
        TAP_FIXED    = 1'b0,
        TAP_VARIABLE = 1'b1
    } tap_mode_e;

    typedef enum logic [2:0] {
        OQ_HOLD,
        OQ_LOAD,
        OQ_ZERO,
        OQ_ONES,
        OQ_INIT
    } oq_op_e;

    // Control request seen by the output register, already gated by configuration
    typedef struct packed {
        logic en;
        logic clr;
        logic set;
        logic init;
    } ctl_req_t;

    function automatic int addr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    function automatic int pipe_depth(input bit variable, input bit speed, input int depth);
        if (!variable || !speed) return 0;
        return (depth > 256) ? 2 : 1;
    endfunction

    function automatic oq_op_e resolve_op(input ctl_req_t r, input bit ctl_over_en,
                                          input bit clear_wins);
        logic act;
        act = ctl_over_en | r.en;
        if (act && r.init) return OQ_INIT;
        if (act && r.clr && r.set) return clear_wins ? OQ_ZERO : OQ_ONES;
        if (act && r.clr) return OQ_ZERO;
        if (act && r.set) return OQ_ONES;
        if (r.en) return OQ_LOAD;
        return OQ_HOLD;
    endfunction

endpackage

// File: rtl/vtap_store.sv
module vtap_store #(
    parameter int               WIDTH  = 8,
    parameter int               STAGES = 16,
    parameter logic [WIDTH-1:0] FILL   = '0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en,
    input  logic [WIDTH-1:0]               din,
    output logic [STAGES-1:0][WIDTH-1:0]   taps
);

    for (genvar i = 0; i < STAGES; i++) begin : g_cell
        logic [WIDTH-1:0] feed;
        logic [WIDTH-1:0] cell_q;

        if (i == 0) begin : g_head
            assign feed = din;
        end else begin : g_body
            assign feed = taps[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst)     cell_q <= FILL;
            else if (en) cell_q <= feed;
        end

        assign taps[i] = cell_q;
    end

endmodule

// File: rtl/vtap_tap_sel.sv
module vtap_tap_sel #(
    parameter int               WIDTH  = 8,
    parameter int               N      = 16,
    parameter int               AW     = 4,
    parameter int               LEVELS = 1,
    parameter logic [WIDTH-1:0] FILL   = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [N-1:0][WIDTH-1:0]   taps,
    input  logic [AW-1:0]             addr,
    output logic [WIDTH-1:0]          dout
);

    logic [AW-1:0] sel_idx;
    assign sel_idx = (int'(addr) >= N) ? AW'(N - 1) : addr;

    if (LEVELS == 0) begin : g_comb
        assign dout = taps[sel_idx];
    end else if (LEVELS == 1) begin : g_one
        logic [WIDTH-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (rst)     rd_q <= FILL;
            else if (en) rd_q <= taps[sel_idx];
        end
        assign dout = rd_q;
    end else begin : g_two
        localparam int LB = 4;
        localparam int G  = 1 << LB;
        localparam int NG = (N + G - 1) / G;
        localparam int HB = AW - LB;

        logic [NG-1:0][WIDTH-1:0] grp_q;
        logic [HB-1:0]            hi_q;
        logic [WIDTH-1:0]         out_q;

        for (genvar g = 0; g < NG; g++) begin : g_grp
            localparam int BASE = g * G;
            logic [WIDTH-1:0] pick;
            always_comb begin
                pick = taps[N-1];
                for (int j = 0; j < G; j++) begin
                    if (sel_idx[LB-1:0] == LB'(j))
                        pick = taps[(BASE + j < N) ? BASE + j : N - 1];
                end
            end
            always_ff @(posedge clk) begin
                if (rst)     grp_q[g] <= FILL;
                else if (en) grp_q[g] <= pick;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q  <= '0;
                out_q <= FILL;
            end else if (en) begin
                hi_q  <= sel_idx[AW-1:LB];
                out_q <= grp_q[hi_q];
            end
        end
        assign dout = out_q;
    end

endmodule

// File: rtl/vtap_out_stage.sv
module vtap_out_stage
    import vtap_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter bit               PRESENT  = 1'b1,
    parameter logic [WIDTH-1:0] PWRON    = '0,
    parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  oq_op_e           op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    if (PRESENT) begin : g_reg
        logic [WIDTH-1:0] q_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                q_r <= PWRON;
            end else begin
                case (op)
                    OQ_LOAD: q_r <= din;
                    OQ_ZERO: q_r <= '0;
                    OQ_ONES: q_r <= '1;
                    OQ_INIT: q_r <= INIT_VAL;
                    default: q_r <= q_r;
                endcase
            end
        end
        assign q = q_r;
    end else begin : g_wire
        assign q = din;
    end

endmodule

// File: rtl/vtap_delay.sv
module vtap_delay
    import vtap_pkg::*;
#(
    parameter int               WIDTH        = 8,
    parameter int               DEPTH        = 16,
    parameter tap_mode_e        MODE         = TAP_VARIABLE,
    parameter bit               OUT_REG      = 1'b1,
    parameter bit               SPEED        = 1'b1,
    parameter bit               HAS_CE       = 1'b1,
    parameter bit               HAS_SCLR     = 1'b1,
    parameter bit               HAS_SSET     = 1'b1,
    parameter bit               HAS_SINIT    = 1'b0,
    parameter bit               CLEAR_WINS   = 1'b1,
    parameter bit               CTRL_OVER_CE = 1'b0,
    parameter logic [WIDTH-1:0] PWRON_VAL    = '0,
    parameter logic [WIDTH-1:0] INIT_VAL     = '0,
    parameter logic [WIDTH-1:0] FILL_VAL     = '0,
    localparam int              AW           = addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    input  logic [AW-1:0]    addr,
    input  logic             sclr,
    input  logic             sset,
    input  logic             sinit,
    output logic [WIDTH-1:0] q
);

    localparam bit IS_VAR  = (MODE == TAP_VARIABLE);
    localparam bit BYPASS  = !IS_VAR && OUT_REG && (DEPTH == 1);
    localparam int STORE_N = IS_VAR ? DEPTH
                                    : (BYPASS ? 1 : (OUT_REG ? DEPTH - 1 : DEPTH));
    localparam int PIPE_N  = pipe_depth(IS_VAR, SPEED, DEPTH);

    // Configuration gating of the control pins
    logic ce_eff, clr_eff, set_eff, init_eff;
    assign ce_eff   = HAS_CE ? ce : 1'b1;
    assign init_eff = (OUT_REG && HAS_SINIT) ? sinit : 1'b0;
    assign clr_eff  = (OUT_REG && HAS_SCLR && !HAS_SINIT) ? sclr : 1'b0;
    assign set_eff  = (OUT_REG && HAS_SSET && !HAS_SINIT) ? sset : 1'b0;

    ctl_req_t req;
    oq_op_e   op;
    assign req = '{en: ce_eff, clr: clr_eff, set: set_eff, init: init_eff};
    assign op  = resolve_op(req, CTRL_OVER_CE, CLEAR_WINS);

    logic [STORE_N-1:0][WIDTH-1:0] taps;
    logic [WIDTH-1:0]              head_word;
    logic [WIDTH-1:0]              tap_word;

    vtap_store #(
        .WIDTH  (WIDTH),
        .STAGES (STORE_N),
        .FILL   (FILL_VAL)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .en   (ce_eff),
        .din  (d),
        .taps (taps)
    );

    assign head_word = taps[0];

    if (IS_VAR) begin : g_var
        vtap_tap_sel #(
            .WIDTH  (WIDTH),
            .N      (STORE_N),
            .AW     (AW),
            .LEVELS (PIPE_N),
            .FILL   (FILL_VAL)
        ) u_sel (
            .clk  (clk),
            .rst  (rst),
            .en   (ce_eff),
            .taps (taps),
            .addr (addr),
            .dout (tap_word)
        );
    end else if (BYPASS) begin : g_bypass
        assign tap_word = d;
    end else begin : g_fixed
        assign tap_word = taps[STORE_N-1];
    end

    vtap_out_stage #(
        .WIDTH    (WIDTH),
        .PRESENT  (OUT_REG),
        .PWRON    (PWRON_VAL),
        .INIT_VAL (INIT_VAL)
    ) u_out (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (tap_word),
        .q   (q)
    );

endmodule

// File: rtl/vtap_delay_chk.sv
module vtap_delay_chk #(
    parameter int               WIDTH        = 8,
    parameter bit               OUT_REG      = 1'b1,
    parameter bit               CTRL_OVER_CE = 1'b0,
    parameter bit               CLEAR_WINS   = 1'b1,
    parameter logic [WIDTH-1:0] PWRON_VAL    = '0,
    parameter logic [WIDTH-1:0] INIT_VAL     = '0,
    parameter logic [WIDTH-1:0] FILL_VAL     = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic             sclr,
    input logic             sset,
    input logic             sinit,
    input logic [WIDTH-1:0] d,
    input logic [WIDTH-1:0] head,
    input logic [WIDTH-1:0] q
);

    logic act;
    assign act = CTRL_OVER_CE || ce;

    // R1
    pwron_value_chk: assert property (@(posedge clk)
        rst |=> (q == (OUT_REG ? PWRON_VAL : FILL_VAL)));

    // R3
    head_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> (head == $past(d)));

    // R5
    stall_head_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(head));

    // R5
    stall_out_chk: assert property (@(posedge clk) disable iff (rst)
        (OUT_REG && !ce && !(CTRL_OVER_CE && (sclr || sset || sinit))) |=> $stable(q));

    // R7
    clear_load_chk: assert property (@(posedge clk) disable iff (rst)
        (OUT_REG && act && sclr && !sinit && (CLEAR_WINS || !sset)) |=> (q == '0));

    // R7
    set_load_chk: assert property (@(posedge clk) disable iff (rst)
        (OUT_REG && act && sset && !sinit && !(CLEAR_WINS && sclr)) |=> (q == '1));

    // R9
    init_load_chk: assert property (@(posedge clk) disable iff (rst)
        (OUT_REG && act && sinit) |=> (q == INIT_VAL));

endmodule

bind vtap_delay vtap_delay_chk #(
    .WIDTH        (WIDTH),
    .OUT_REG      (OUT_REG),
    .CTRL_OVER_CE (CTRL_OVER_CE),
    .CLEAR_WINS   (CLEAR_WINS),
    .PWRON_VAL    (PWRON_VAL),
    .INIT_VAL     (INIT_VAL),
    .FILL_VAL     (FILL_VAL)
) u_vtap_chk (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce_eff),
    .sclr  (clr_eff),
    .sset  (set_eff),
    .sinit (init_eff),
    .d     (d),
    .head  (head_word),
    .q     (q)
);

// File: tb/vtap_delay_bench.sv
module vtap_delay_bench;
    import vtap_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       ce_a, sclr_a, sset_a;
    logic [7:0] d_a, q_a;
    logic [3:0] addr_a;
    logic       ce_b, sset_b, sinit_b;
    logic [7:0] d_b, q_b;

    vtap_delay #(
        .WIDTH(8), .DEPTH(16), .MODE(TAP_VARIABLE), .OUT_REG(1'b1), .SPEED(1'b1),
        .HAS_CE(1'b1), .HAS_SCLR(1'b1), .HAS_SSET(1'b1), .HAS_SINIT(1'b0),
        .CLEAR_WINS(1'b1), .CTRL_OVER_CE(1'b0),
        .PWRON_VAL(8'hA5), .INIT_VAL(8'h00), .FILL_VAL(8'h3C)
    ) u_vtap_delay (
        .clk(clk), .rst(rst), .ce(ce_a), .d(d_a), .addr(addr_a),
        .sclr(sclr_a), .sset(sset_a), .sinit(1'b0), .q(q_a)
    );

    vtap_delay #(
        .WIDTH(8), .DEPTH(5), .MODE(TAP_FIXED), .OUT_REG(1'b1), .SPEED(1'b0),
        .HAS_CE(1'b1), .HAS_SCLR(1'b0), .HAS_SSET(1'b1), .HAS_SINIT(1'b1),
        .CLEAR_WINS(1'b1), .CTRL_OVER_CE(1'b1),
        .PWRON_VAL(8'h5A), .INIT_VAL(8'h96), .FILL_VAL(8'hC3)
    ) u_fixed (
        .clk(clk), .rst(rst), .ce(ce_b), .d(d_b), .addr(3'd0),
        .sclr(1'b0), .sset(sset_b), .sinit(sinit_b), .q(q_b)
    );

    // Behavioural expectation of both instances
    logic [7:0] ha [16];
    logic [7:0] pa, qa_m;
    logic [7:0] hb [4];
    logic [7:0] qb_m;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    task automatic model_edge();
        logic [7:0] tapv;
        logic [7:0] lastb;
        if (rst) begin
            for (int j = 0; j < 16; j++) ha[j] = 8'h3C;
            pa   = 8'h3C;
            qa_m = 8'hA5;
            for (int j = 0; j < 4; j++) hb[j] = 8'hC3;
            qb_m = 8'h5A;
        end else begin
            tapv = ha[addr_a];
            if (ce_a) begin
                if (sclr_a)      qa_m = 8'h00;
                else if (sset_a) qa_m = 8'hFF;
                else             qa_m = pa;
                pa = tapv;
                for (int j = 15; j > 0; j--) ha[j] = ha[j-1];
                ha[0] = d_a;
            end
            lastb = hb[3];
            if (sinit_b)   qb_m = 8'h96;
            else if (ce_b) qb_m = lastb;
            if (ce_b) begin
                for (int j = 3; j > 0; j--) hb[j] = hb[j-1];
                hb[0] = d_b;
            end
        end
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
        check(q_a, qa_m, "variable q");
        check(q_b, qb_m, "fixed q");
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        int seed_init;
        seed_init = $urandom(32'h5EED);
        rst = 1'b1; ce_a = 0; sclr_a = 0; sset_a = 0; d_a = 0; addr_a = 0;
        ce_b = 0; sset_b = 0; sinit_b = 0; d_b = 0;
        @(negedge clk);

        // R1: reset values, then fill words flush out
        tag = "R1";
        for (int i = 0; i < 3; i++) step();
        check(q_a, 8'hA5, "reset power-on word");
        check(q_b, 8'h5A, "reset power-on word");
        rst = 1'b0; ce_a = 1; ce_b = 1; addr_a = 4'd15;
        for (int i = 0; i < 20; i++) begin
            d_a = 8'($urandom); d_b = 8'($urandom);
            step();
        end

        // R2: fixed delay of 5 edges counting the output register
        tag = "R2";
        d_b = 8'h00;
        for (int i = 0; i < 6; i++) step();
        d_b = 8'h11; step();
        d_b = 8'h00;
        for (int i = 0; i < 3; i++) step();
        check(q_b, 8'h00, "marker not before 5th edge");
        step();
        check(q_b, 8'h11, "marker at 5th edge");
        for (int i = 0; i < 30; i++) begin
            d_b = 8'($urandom); d_a = 8'($urandom);
            step();
        end

        // R3: fixed addresses, several depths
        tag = "R3";
        for (int k = 0; k < 3; k++) begin
            addr_a = (k == 0) ? 4'd0 : ((k == 1) ? 4'd7 : 4'd15);
            for (int i = 0; i < 25; i++) begin
                d_a = 8'($urandom);
                step();
            end
        end

        // R6: speed pipeline adds exactly one cycle (address 0 -> 3 edges)
        tag = "R6";
        addr_a = 4'd0; d_a = 8'h00;
        for (int i = 0; i < 4; i++) step();
        d_a = 8'hE7; step();
        d_a = 8'h00; step();
        check(q_a, 8'h00, "marker not at 2nd edge");
        step();
        check(q_a, 8'hE7, "marker at 3rd edge");

        // R4: lossless address moves
        tag = "R4";
        addr_a = 4'd0;
        for (int i = 0; i < 16; i++) begin
            d_a = 8'(i + 1);
            step();
        end
        d_a = 8'h80; addr_a = 4'd9;
        step(); step();
        check(q_a, 8'd7, "word stored at new tap");
        for (int i = 0; i < 60; i++) begin
            d_a = 8'($urandom); addr_a = 4'($urandom);
            step();
        end

        // R5: stalls
        tag = "R5";
        addr_a = 4'd5;
        for (int i = 0; i < 60; i++) begin
            d_a = 8'($urandom); d_b = 8'($urandom);
            ce_a = 1'($urandom); ce_b = 1'($urandom);
            step();
        end
        ce_a = 0; ce_b = 0;
        held = q_a;
        for (int i = 0; i < 5; i++) begin
            d_a = 8'($urandom); d_b = 8'($urandom);
            step();
        end
        check(q_a, held, "output held while stalled");
        ce_a = 1; ce_b = 1;

        // R7: clear / set with clear winning
        tag = "R7";
        for (int i = 0; i < 60; i++) begin
            d_a = 8'($urandom); addr_a = 4'($urandom);
            sclr_a = ($urandom % 4) == 0; sset_a = ($urandom % 4) == 0;
            step();
        end
        sclr_a = 1; sset_a = 1; step();
        check(q_a, 8'h00, "clear beats set");
        sclr_a = 0; sset_a = 1; step();
        check(q_a, 8'hFF, "set alone");
        sset_a = 0;

        // R8: control qualification by the enable
        tag = "R8";
        step();
        held = q_a;
        ce_a = 0; sclr_a = 1; step();
        check(q_a, held, "clear gated by low enable");
        sclr_a = 0; ce_a = 1;
        ce_b = 0; sinit_b = 1; step();
        check(q_b, 8'h96, "init overrides low enable");
        sinit_b = 0; ce_b = 1;

        // R9: init, and set ignored beside it
        tag = "R9";
        for (int i = 0; i < 40; i++) begin
            d_b = 8'($urandom); ce_b = ($urandom % 4) != 0;
            sset_b = 1'($urandom); sinit_b = ($urandom % 10) < 3;
            step();
        end
        sinit_b = 0; ce_b = 1; sset_b = 0;
        for (int i = 0; i < 6; i++) begin
            d_b = 8'h21;
            step();
        end
        sset_b = 1; step();
        check(q_b, 8'h21, "set ignored with init configured");
        sset_b = 0;

        // R10: control pulses leave the stream intact
        tag = "R10";
        addr_a = 4'd3;
        for (int i = 0; i < 40; i++) begin
            d_a = 8'($urandom);
            sclr_a = (i % 7) == 3;
            sset_a = (i % 11) == 5;
            step();
        end
        sclr_a = 0; sset_a = 0;
        for (int i = 0; i < 8; i++) begin
            d_a = 8'($urandom);
            step();
        end

        finish_run();
    end

endmodule